// File: doc/BRIEF.md
# Strided Banked Vector Memory Engine

This block moves one vector between a 64-slot vector register and an on-block memory of 16 independently timed, word-interleaved banks. A request carries a direction (load or store), a base word address, a stride and an element count. The engine walks the element addresses one per cycle at most: the first is the base and each next one adds the stride, modulo the address space. The low four address bits pick the bank and the upper bits pick the row inside it.

All banks hang off one shared request bus and one shared return bus, so no more than one access starts in a cycle. A bank stays occupied for 11 cycles after it accepts an access. The engine holds the next element only when its target bank is still occupied; it never stalls on any other condition. Loaded words come back in element order and are written into slot i of the vector register. Stores read slot i of the register in the cycle element i is issued. A one-cycle completion pulse follows the last access.

The controller has four states. IDLE waits for a request; with a zero count it goes straight to FINISH, otherwise to ISSUE. ISSUE sends one element per free-bank cycle and goes to DRAIN once it has issued the last element. DRAIN waits until no access is in flight and then goes to FINISH. FINISH raises the pulse for one cycle and returns to IDLE.

Top module: `svm_engine`

## Requirements
- R1: Element i targets word address (base + i*stride) mod 256; the bank is address bits [3:0] and the row is bits [7:4].
- R2: The first element issues in the cycle after the request is accepted. Each later element issues at the earliest cycle that is after the previous issue and at which its bank is free. At most one access starts per cycle.
- R3: A bank that accepts an access at cycle t accepts no other access before cycle t+11.
- R4: For a load (op_store=0), element i is written to slot i exactly 11 cycles after it issues. vr_widx=i, vr_wdata equals the memory word at element i's address, and writes arrive in ascending slot order.
- R5: For a store (op_store=1), the word on vr_rdata while vr_ridx=i is written to element i's address. A store never asserts vr_we. When two elements hit the same address, the later element wins.
- R6: done is a single-cycle pulse seen 12 cycles after the edge that issued the last element.
- R7: A request with vlen=0 raises done in the cycle right after acceptance. It performs no access and no register write.
- R8: A vlen above 64 is treated as 64.
- R9: With a stride coprime to 16 (for example 1 or 3), an n-element transfer issues one element per cycle, and done follows vlen+12 cycles after acceptance.
- R10: With a stride of 0 or 16, every element after the first waits the full 11-cycle bank occupancy.
- R11: After reset, done and vr_we are low and every memory word reads as zero.
- R12: start is ignored while a transfer is in progress (any state other than IDLE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request strobe, accepted in IDLE |
| op_store | input | 1 | 1 = store register to memory, 0 = load |
| base_addr | input | 8 | Word address of element 0 |
| stride | input | 8 | Address increment between elements |
| vlen | input | 7 | Element count (clamped to 64) |
| vr_ridx | output | 6 | Register slot read for a store |
| vr_rdata | input | 32 | Register data for slot vr_ridx |
| vr_we | output | 1 | Register write strobe for loaded data |
| vr_widx | output | 6 | Register slot written |
| vr_wdata | output | 32 | Loaded word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Unit stride and stride 3 must run at full rate, so they expose any stall that has no cause. Stride 2 reuses a bank after 8 cycles, which exposes a busy timer that is too short or too long by comparing exact write cycles. Strides 0 and 16 serialize on one bank and pin the occupancy length exactly. Wraparound bases, zero and oversized counts, a stray start during a transfer, and loads that read back stores with repeated addresses separate address arithmetic, clamping, request gating and write ordering.

// File: rtl/svm_pkg.sv
package svm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } eng_state_e;
endpackage

// File: rtl/svm_addr_gen.sv
module svm_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
        end else if (load_i) begin
            addr_q   <= base_i;
            stride_q <= stride_i;
        end else if (step_i) begin
            addr_q   <= addr_q + stride_q;
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/svm_bank.sv
module svm_bank #(
    parameter int ROW_W  = 4,
    parameter int DATA_W = 32,
    parameter int LAT    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o
);
    localparam int ROWS  = 1 << ROW_W;
    localparam int TMR_W = $clog2(LAT + 1);

    logic [DATA_W-1:0] mem_q [ROWS];
    logic [TMR_W-1:0]  tmr_q;

    // remaining occupied cycles after the current one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (sel_i) begin
            tmr_q <= TMR_W'(LAT - 1);
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (sel_i && we_i) begin
            mem_q[row_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[row_i];
    assign busy_o  = (tmr_q != '0);

    AST_NO_BUSY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i |-> !busy_o) else $error("bank accepted while occupied"); // R3
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && LAT > 1) |=> busy_o) else $error("bank free right after accept"); // R3
endmodule

// File: rtl/svm_ret_pipe.sv
module svm_ret_pipe #(
    parameter int DEPTH  = 11,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              load_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              out_valid_o,
    output logic              out_load_o,
    output logic [IDX_W-1:0]  out_idx_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              empty_o
);
    logic              v_q [DEPTH];
    logic              l_q [DEPTH];
    logic [IDX_W-1:0]  i_q [DEPTH];
    logic [DATA_W-1:0] d_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) v_q[d] <= 1'b0;
        end else begin
            v_q[0] <= push_i;
            for (int d = 1; d < DEPTH; d++) v_q[d] <= v_q[d-1];
        end
    end

    always_ff @(posedge clk) begin
        l_q[0] <= load_i;
        i_q[0] <= idx_i;
        d_q[0] <= data_i;
        for (int d = 1; d < DEPTH; d++) begin
            l_q[d] <= l_q[d-1];
            i_q[d] <= i_q[d-1];
            d_q[d] <= d_q[d-1];
        end
    end

    always_comb begin
        empty_o = 1'b1;
        for (int d = 0; d < DEPTH; d++) begin
            if (v_q[d]) empty_o = 1'b0;
        end
    end

    assign out_valid_o = v_q[DEPTH-1];
    assign out_load_o  = l_q[DEPTH-1];
    assign out_idx_o   = i_q[DEPTH-1];
    assign out_data_o  = d_q[DEPTH-1];
endmodule

// File: rtl/svm_engine.sv
module svm_engine
    import svm_pkg::*;
#(
    parameter int N_BANKS = 16,
    parameter int LAT     = 11,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int VREG_N  = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        op_store,
    input  logic [ADDR_W-1:0]           base_addr,
    input  logic [ADDR_W-1:0]           stride,
    input  logic [$clog2(VREG_N+1)-1:0] vlen,
    output logic [$clog2(VREG_N)-1:0]   vr_ridx,
    input  logic [DATA_W-1:0]           vr_rdata,
    output logic                        vr_we,
    output logic [$clog2(VREG_N)-1:0]   vr_widx,
    output logic [DATA_W-1:0]           vr_wdata,
    output logic                        done
);
    localparam int BANK_W = $clog2(N_BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int IDX_W  = $clog2(VREG_N);
    localparam int LEN_W  = $clog2(VREG_N + 1);

    eng_state_e        state_q, state_d;
    logic              op_store_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  elem_q;
    logic [LEN_W-1:0]  vlen_eff;
    logic              accept;
    logic              issue_fire;
    logic              last_elem;
    logic [ADDR_W-1:0] cur_addr;
    logic [BANK_W-1:0] tgt_bank;
    logic [ROW_W-1:0]  tgt_row;
    logic [N_BANKS-1:0] bank_sel;
    logic              bank_busy  [N_BANKS];
    logic [DATA_W-1:0] bank_rdata [N_BANKS];
    logic              ret_valid, ret_load, pipe_empty;

    assign vlen_eff   = (vlen > LEN_W'(VREG_N)) ? LEN_W'(VREG_N) : vlen;
    assign accept     = (state_q == ST_IDLE) && start;
    assign tgt_bank   = cur_addr[BANK_W-1:0];
    assign tgt_row    = cur_addr[ADDR_W-1:BANK_W];
    assign issue_fire = (state_q == ST_ISSUE) && !bank_busy[tgt_bank];
    assign last_elem  = (LEN_W'(elem_q) + LEN_W'(1)) == len_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (vlen == '0) ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  if (issue_fire && last_elem) state_d = ST_DRAIN;
            ST_DRAIN:  if (pipe_empty) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request capture and element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_store_q <= 1'b0;
            len_q      <= '0;
            elem_q     <= '0;
        end else if (accept) begin
            op_store_q <= op_store;
            len_q      <= vlen_eff;
            elem_q     <= '0;
        end else if (issue_fire) begin
            elem_q     <= elem_q + IDX_W'(1);
        end
    end

    svm_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .base_i   (base_addr),
        .stride_i (stride),
        .step_i   (issue_fire),
        .addr_o   (cur_addr)
    );

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        assign bank_sel[g] = issue_fire && (tgt_bank == BANK_W'(g));
        svm_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W), .LAT(LAT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (bank_sel[g]),
            .we_i    (op_store_q),
            .row_i   (tgt_row),
            .wdata_i (vr_rdata),
            .rdata_o (bank_rdata[g]),
            .busy_o  (bank_busy[g])
        );
    end

    svm_ret_pipe #(.DEPTH(LAT), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (issue_fire),
        .load_i      (!op_store_q),
        .idx_i       (elem_q),
        .data_i      (op_store_q ? '0 : bank_rdata[tgt_bank]),
        .out_valid_o (ret_valid),
        .out_load_o  (ret_load),
        .out_idx_o   (vr_widx),
        .out_data_o  (vr_wdata),
        .empty_o     (pipe_empty)
    );

    // outputs
    always_comb begin
        done    = (state_q == ST_FINISH);
        vr_ridx = elem_q;
        vr_we   = ret_valid && ret_load;
    end

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel)) else $error("two bank accesses started"); // R2
    AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |=> (!vr_we || vr_widx == IDX_W'($past(vr_widx) + IDX_W'(1))))
        else $error("register writes out of order"); // R4
    AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |-> !op_store_q) else $error("store wrote register"); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held"); // R6
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vlen == '0) |=> (done && pipe_empty)) else $error("empty request not immediate"); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(op_store_q) && $stable(len_q)))
        else $error("request changed mid-transfer"); // R12
endmodule

// File: tb/test_svm_engine.sv
module test_svm_engine;
    localparam int LAT = 11;
    localparam int NB  = 16;
    localparam int VN  = 64;

    typedef struct {
        int          cyc;
        int          idx;
        logic [31:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_store = 1'b0;
    logic [7:0]  base_addr = '0;
    logic [7:0]  stride = '0;
    logic [6:0]  vlen = '0;
    logic [5:0]  vr_ridx;
    logic [31:0] vr_rdata;
    logic        vr_we;
    logic [5:0]  vr_widx;
    logic [31:0] vr_wdata;
    logic        done;

    logic [31:0] vreg   [VN];
    logic [31:0] shadow [256];
    exp_t        q[$];
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    string       cur_req = "R11";

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign vr_rdata = vreg[vr_ridx];

    svm_engine i_svm_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
        .base_addr(base_addr), .stride(stride), .vlen(vlen),
        .vr_ridx(vr_ridx), .vr_rdata(vr_rdata), .vr_we(vr_we),
        .vr_widx(vr_widx), .vr_wdata(vr_wdata), .done(done)
    );

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && vr_we) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected write idx=%0d data=%h, expected none", cur_req, vr_widx, vr_wdata);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.cyc != cyc || e.idx != int'(vr_widx) || e.data !== vr_wdata) begin
                    errors++;
                    $display("FAIL %s: write cyc=%0d idx=%0d data=%h, expected cyc=%0d idx=%0d data=%h",
                             cur_req, cyc, vr_widx, vr_wdata, e.cyc, e.idx, e.data);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input bit st, input int base, input int strd, input int len,
                          input string req, input bit spur);
        int n, t, s, tl, a, b, w, exp_done;
        int bfree[NB];
        n = (len > VN) ? VN : len;
        cur_req = req;
        @(negedge clk);
        op_store = st; base_addr = 8'(base); stride = 8'(strd); vlen = 7'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        s = cyc;
        foreach (bfree[k]) bfree[k] = 0;
        t = s + 1; a = base % 256; tl = s;
        for (int i = 0; i < n; i++) begin
            b = a % NB;
            if (bfree[b] > t) t = bfree[b];
            bfree[b] = t + LAT;
            if (st) shadow[a] = vreg[i];
            else q.push_back('{t + LAT - 1, i, shadow[a]});
            tl = t; t++;
            a = (a + strd) % 256;
        end
        exp_done = (n == 0) ? s : tl + LAT + 1;
        if (spur) begin
            repeat (3) @(negedge clk);
            op_store = ~st; base_addr = 8'd99; stride = 8'd5; vlen = 7'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 3000) begin
            @(negedge clk);
            w++;
        end
        check(cyc == exp_done, {req, " done cycle"}, cyc, exp_done);
        @(negedge clk);
        check(!done, {req, " R6 done single pulse"}, int'(done), 0);
        check(q.size() == 0, {req, " pending writes"}, q.size(), 0);
        q.delete();
    endtask

    initial begin
        foreach (shadow[k]) shadow[k] = '0;
        foreach (vreg[k]) vreg[k] = 32'hA000_0000 + 32'(k * 3 + 1);
        repeat (3) @(negedge clk);
        check(!done && !vr_we, "R11 reset outputs", int'(done) + int'(vr_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !vr_we, "R11 idle outputs", int'(done) + int'(vr_we), 0);

        run_op(0, 0, 1, 8, "R11 R4 zeros after reset", 0);
        run_op(1, 0, 1, 64, "R5 R9 unit-stride store", 0);
        run_op(0, 0, 1, 64, "R4 R9 unit-stride load", 0);
        foreach (vreg[k]) vreg[k] = 32'hB000_0000 ^ (32'(k) * 32'h0101_0101);
        run_op(1, 5, 3, 40, "R9 R1 stride3 store", 0);
        run_op(0, 5, 3, 40, "R9 R1 stride3 load", 0);
        run_op(0, 1, 2, 20, "R2 R3 stride2 stalls", 0);
        run_op(0, 7, 0, 4, "R10 stride0 load", 0);
        run_op(1, 3, 16, 3, "R10 R5 stride16 store", 0);
        run_op(0, 3, 16, 5, "R10 stride16 load", 0);
        run_op(1, 9, 0, 5, "R5 stride0 store last wins", 0);
        run_op(0, 9, 1, 2, "R5 readback last element", 0);
        foreach (vreg[k]) vreg[k] = 32'hDEAD_0000 + 32'(k);
        run_op(1, 0, 1, 0, "R7 empty store", 0);
        run_op(0, 0, 1, 0, "R7 empty load", 0);
        run_op(0, 0, 1, 100, "R8 R7 clamp and unchanged memory", 0);
        run_op(1, 250, 7, 30, "R1 wraparound store", 0);
        run_op(0, 250, 7, 30, "R1 wraparound load", 0);
        run_op(0, 4, 1, 40, "R12 stray start", 1);
        run_op(0, 99, 5, 3, "R12 stray start had no effect", 0);
        run_op(0, 128, 1, 64, "R4 upper half", 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule